// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block decides when a small CPU core should divert into an interrupt service routine. Two sources feed it: a one-cycle overflow pulse from a timer, and an asynchronous external pin. Software reads and writes an 8-bit control byte. The byte holds a master enable, one enable per source and one pending flag per source. The pin passes through a two-stage synchronizer. The active edge on the pin is chosen by the level of a separate port output: that output high selects falling edges, and that output low selects rising edges.

When a pending source is enabled and the master enable is set, the block issues a one-cycle take strobe with a fixed vector address. The timer vector is 08H and the pin vector is 04H. In the same step it clears the master enable and the serviced flag, so the service routine cannot be interrupted again. The CPU reports when its return stack is full. While that signal is high, nothing is taken. Pending flags keep collecting while the master enable is off and are serviced later. A separate wake strobe tells the halt logic that an enabled source has just become pending.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the control byte reads 00H. Its fields are: bit 0 master enable, bit 1 pin enable, bit 2 timer enable, bit 4 pin flag, bit 5 timer flag. Bits 3, 6 and 7 always read 0. A write with `reg_wr` high loads the byte on the next clock edge.
- R2: A high `tmr_ovf` in a cycle sets the timer flag (bit 5) at that clock edge.
- R3: The pin is sampled by two flip-flops, and an edge is then detected between consecutive synchronized samples. With `edge_sel` low, only a low-to-high pin change sets the pin flag (bit 4). With `edge_sel` high, only a high-to-low change sets it. A change of the wrong direction leaves the flag clear.
- R4: Suppose the master enable is set, some source has both its enable and its flag set, `stack_full` is low and no write occurs in that cycle. Then on the next edge `take` pulses for one cycle with `vec_addr` at the source vector (04H pin, 08H timer). At the same edge the master enable and that source's flag clear.
- R5: When both sources are eligible in the same cycle, the pin source (04H) is taken first and the timer flag stays set.
- R6: While `stack_full` is high, no take occurs and the flags are kept. Once it falls, the pending interrupt is taken.
- R7: With the master enable clear, source events still set their flags, and no take occurs until software sets the master enable.
- R8: `wake` pulses for one cycle, one edge after a source flag goes from 0 to 1 while that source's enable is set. The master enable does not affect this.
- R9: If a hardware set event and a software write that clears the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Current control byte |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_sel | input | 1 | 1 selects falling edge, 0 selects rising edge |
| stack_full | input | 1 | Return stack full, holds off all takes |
| take | output | 1 | One-cycle interrupt take strobe |
| vec_addr | output | 8 | Vector address, valid with `take` |
| wake | output | 1 | One-cycle wake-up request |

## Verification
The hardest situation to reach is two sources eligible in the very same cycle, with one of them still pending after the first take. The stimulus gets there by setting both source enables with the master enable off. It then fires a timer pulse and a falling pin edge, so both flags pile up. Finally it turns on the master enable with a single write. After that take, the bench re-enables the master enable to drain the timer request. It also holds `stack_full` high over a pending request and checks that the scoreboard sees no take until it drops.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_W     = 8;
    localparam int VEC_W     = 8;
    localparam int B_GIE     = 0;
    localparam int B_EIE     = 1;
    localparam int B_TIE     = 2;
    localparam int B_EIF     = 4;
    localparam int B_TIF     = 5;
    localparam logic [VEC_W-1:0] EXT_VEC = 8'h04;
    localparam logic [VEC_W-1:0] TMR_VEC = 8'h08;

    typedef struct packed {
        logic gie;
        logic eie;
        logic tie;
        logic eif;
        logic tif;
    } irq_state_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_TMR  = 2'd2
    } irq_src_e;

    function automatic irq_state_t unpack_reg(input logic [REG_W-1:0] d);
        irq_state_t s;
        s.gie = d[B_GIE];
        s.eie = d[B_EIE];
        s.tie = d[B_TIE];
        s.eif = d[B_EIF];
        s.tif = d[B_TIF];
        return s;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input irq_state_t s);
        logic [REG_W-1:0] d;
        d        = '0;
        d[B_GIE] = s.gie;
        d[B_EIE] = s.eie;
        d[B_TIE] = s.tie;
        d[B_EIF] = s.eif;
        d[B_TIF] = s.tif;
        return d;
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[LAST];
        end
    end

    always_comb begin
        if (fall_sel)
            edge_o = prev_q & ~sync_q[LAST];
        else
            edge_o = ~prev_q & sync_q[LAST];
    end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ext_set,
    input  logic             tmr_set,
    input  logic             clr_ext,
    input  logic             clr_tmr,
    output irq_state_t       state_o,
    output logic             wake_o
);
    irq_state_t cur_q, base, nxt;
    logic       wake_d;

    always_comb begin
        base     = wr ? unpack_reg(wdata) : cur_q;
        nxt      = base;
        nxt.gie  = base.gie & ~(clr_ext | clr_tmr);
        nxt.eif  = (base.eif & ~clr_ext) | ext_set;
        nxt.tif  = (base.tif & ~clr_tmr) | tmr_set;
        wake_d   = (nxt.eif & ~cur_q.eif & nxt.eie) |
                   (nxt.tif & ~cur_q.tif & nxt.tie);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            wake_o <= 1'b0;
        end else begin
            cur_q  <= nxt;
            wake_o <= wake_d;
        end
    end

    assign state_o = cur_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_state_t       state,
    input  logic             stack_full,
    input  logic             wr,
    output logic             grant_ext,
    output logic             grant_tmr,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o
);
    logic     req_ext, req_tmr, allow;
    irq_src_e sel;

    always_comb begin
        req_ext   = state.gie & state.eie & state.eif;
        req_tmr   = state.gie & state.tie & state.tif;
        allow     = ~stack_full & ~wr;
        grant_ext = allow & req_ext;
        grant_tmr = allow & req_tmr & ~req_ext;
        if (grant_ext)      sel = SRC_EXT;
        else if (grant_tmr) sel = SRC_TMR;
        else                sel = SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o <= 1'b0;
            vec_o  <= '0;
        end else begin
            take_o <= (sel != SRC_NONE);
            case (sel)
                SRC_EXT: vec_o <= EXT_VEC;
                SRC_TMR: vec_o <= TMR_VEC;
                default: vec_o <= vec_o;
            endcase
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tmr_ovf,
    input  logic             ext_pin,
    input  logic             edge_sel,
    input  logic             stack_full,
    output logic             take,
    output logic [VEC_W-1:0] vec_addr,
    output logic             wake
);
    irq_state_t st;
    logic       ext_edge, g_ext, g_tmr;

    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(ext_pin), .fall_sel(edge_sel), .edge_o(ext_edge)
    );

    irq_ctrl_reg u_reg (
        .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
        .ext_set(ext_edge), .tmr_set(tmr_ovf),
        .clr_ext(g_ext), .clr_tmr(g_tmr),
        .state_o(st), .wake_o(wake)
    );

    irq_arbiter u_arb (
        .clk(clk), .rst(rst), .state(st), .stack_full(stack_full), .wr(reg_wr),
        .grant_ext(g_ext), .grant_tmr(g_tmr), .take_o(take), .vec_o(vec_addr)
    );

    assign reg_rdata = pack_reg(st);
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] reg_rdata,
    input logic             stack_full,
    input logic             take,
    input logic [VEC_W-1:0] vec_addr
);
    p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[3] == 1'b0 && reg_rdata[7:6] == 2'b00);

    p_vec_legal_r4: assert property (@(posedge clk) disable iff (rst)
        take |-> (vec_addr == EXT_VEC || vec_addr == TMR_VEC));

    p_take_needs_gie_r4: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(reg_rdata[B_GIE]));

    p_take_clears_gie_r4: assert property (@(posedge clk) disable iff (rst)
        take |-> !reg_rdata[B_GIE]);

    p_take_single_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    p_ext_first_r5: assert property (@(posedge clk) disable iff (rst)
        (take && $past(reg_rdata[B_EIE] & reg_rdata[B_EIF])) |-> vec_addr == EXT_VEC);

    p_hold_stack_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(!stack_full));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .stack_full(stack_full),
    .take(take), .vec_addr(vec_addr)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tmr_ovf = 1'b0;
    logic       ext_pin = 1'b0;
    logic       edge_sel = 1'b0;
    logic       stack_full = 1'b0;
    logic       take;
    logic [7:0] vec_addr;
    logic       wake;

    int n_chk = 0;
    int n_bad = 0;
    int wake_cnt = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
        .edge_sel(edge_sel), .stack_full(stack_full), .take(take),
        .vec_addr(vec_addr), .wake(wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected vectors as takes appear, counts wake pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (wake) wake_cnt++;
            if (take) begin
                if (exp_q.size() == 0) check("R4/R6 unexpected take", {24'd0, vec_addr}, 32'hFFFF);
                else check("R4/R5 take vector", {24'd0, vec_addr}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tmr_pulse();
        @(negedge clk);
        tmr_ovf = 1'b1;
        @(negedge clk);
        tmr_ovf = 1'b0;
    endtask

    task automatic pin(input logic v);
        @(negedge clk);
        ext_pin = v;
        wait_cyc(6);
    endtask

    task automatic drained(input string req);
        check(req, exp_q.size(), 0);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 reset", reg_rdata, 8'h00);

        // R1: unused bits drop, no enables so no wake
        wr(8'hF8);
        check("R1 field layout", reg_rdata, 8'h30);
        wr(8'h00);
        check("R1 clear", reg_rdata, 8'h00);

        // R7/R2: timer flag waits with master enable off
        wr(8'h04);
        tmr_pulse();
        wait_cyc(3);
        check("R2 R7 timer flag pending", reg_rdata, 8'h24);
        exp_q.push_back(8'h08);
        wr(8'h25);
        wait_cyc(3);
        check("R4 timer take clears", reg_rdata, 8'h04);
        drained("R4 timer taken");

        // R3 rising edge select
        edge_sel = 1'b0;
        wr(8'h03);
        exp_q.push_back(8'h04);
        pin(1'b1);
        check("R3 rising sets flag then take", reg_rdata, 8'h02);
        drained("R3 rising take");
        wr(8'h03);
        pin(1'b0);
        check("R3 falling ignored in rising mode", reg_rdata, 8'h03);

        // R3 falling edge select
        edge_sel = 1'b1;
        pin(1'b1);
        check("R3 rising ignored in falling mode", reg_rdata, 8'h03);
        exp_q.push_back(8'h04);
        pin(1'b0);
        check("R3 falling take", reg_rdata, 8'h02);
        drained("R3 falling drained");

        // R5 priority
        wr(8'h06);
        tmr_pulse();
        pin(1'b1);
        pin(1'b0);
        check("R5 both pending", reg_rdata, 8'h36);
        exp_q.push_back(8'h04);
        wr(8'h37);
        wait_cyc(3);
        check("R5 pin first, timer left", reg_rdata, 8'h26);
        exp_q.push_back(8'h08);
        wr(8'h27);
        wait_cyc(3);
        check("R5 timer second", reg_rdata, 8'h06);
        drained("R5 drained");

        // R6 stack full hold-off
        stack_full = 1'b1;
        wr(8'h05);
        tmr_pulse();
        wait_cyc(6);
        check("R6 held while stack full", reg_rdata, 8'h25);
        exp_q.push_back(8'h08);
        stack_full = 1'b0;
        wait_cyc(3);
        check("R6 taken after release", reg_rdata, 8'h04);
        drained("R6 drained");

        // R9 set beats software clear in same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 8'h04; tmr_ovf = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        check("R9 set wins", reg_rdata, 8'h24);

        wait_cyc(3);
        check("R8 wake pulse count", wake_cnt, 7);
        drained("R4 final queue");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule